// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block is the timekeeping core of an on-chip real-time clock. It keeps a 64-step sub-second count and a calendar in packed BCD: seconds, minutes, hours, weekday, day of month, month, two-digit year and, optionally, a BCD century byte. A free-running tick input is divided by an internal prescaler into sub-second steps. A byte-wide register port lets software load the counters while counting is stopped, read them at any time, and control starting, stopping and prescaler reset.

A full calendar read touches several registers, and a second boundary can fall between two of those accesses. When the sub-second counter wraps into the seconds field, the block sets a sticky carry flag. It also raises an interrupt if software has enabled one. The read routine clears the flag, reads every field, then looks at the flag again. If the flag is set, the routine reads all the fields again.

The carry does not pass through the whole calendar in one cycle. A sequencer moves it one field per clock. Its states are ST_IDLE, ST_SEC, ST_MIN, ST_HOUR, ST_DAY, ST_MON and ST_YEAR, with these transitions:
- ST_IDLE goes to ST_SEC when a step wraps the sub-second counter.
- Each later state goes to the next state when its own field wraps. Otherwise it returns to ST_IDLE.
- ST_DAY also advances the weekday.
- ST_YEAR always returns to ST_IDLE.

Top module: `bcd_rtc_core`

## Requirements
- R1: Register indices on the byte port are 0 sub-second, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 day of month, 6 month, 7 year, 8 century, 14 control A and 15 control B. Reads are combinational. After reset the day and month read 0x01, the century reads 0x20, and every other register reads 0x00. The carry interrupt output is 0 after reset.
- R2: The sub-second counter is a 6-bit binary value, read as 0x00..0x3F. Each prescaler step adds one. A step taken at 0x3F gives 0x00 and starts a one-second carry.
- R3: Seconds and minutes count in BCD and wrap from 0x59 to 0x00. Hours wrap from 0x23 to 0x00. Each wrap carries into the next field.
- R4: On a day carry, the weekday goes 0 to 6 and then back to 0. The day of month wraps to 0x01 after the month's last day. That last day is 0x31, or 0x30 for months 0x04, 0x06, 0x09 and 0x11. For month 0x02 it is 0x28, or 0x29 when the two-digit year is divisible by 4.
- R5: The month wraps from 0x12 to 0x01 and carries into the year. The year wraps from 0x99 to 0x00. With the wide-year parameter set, that year wrap also adds one to the BCD century.
- R6: Writes to indices 0 to 8 take effect only while the start bit is 0. Writes made while it is 1 are ignored. While the start bit is 0, the counters and the sequencer hold their values.
- R7: The prescaler emits one step per PRE_DIV tick pulses, and only while the start bit is 1. With the tick present every clock, the first step after starting comes on the PRE_DIV-th clock. The prescaler reset bit holds the prescaler at zero, so no step occurs while it is set.
- R8: Control A bit 7 (0x80) is the carry flag. It is set on every sub-second wrap and stays set. Writing 0 to the bit clears it, and writing 1 leaves it unchanged. A carry in the same clock as a clearing write leaves the flag set.
- R9: The carry interrupt output is high exactly when the carry flag and the enable bit, control A bit 4 (0x10), are both 1. Control A reads as flag in bit 7, enable in bit 4, and zeros elsewhere.
- R10: Control B reads back start (0x01), prescaler reset (0x02), adjust (0x04) and enable (0x08), with zeros in the upper bits. Adjust and enable are stored only and do not change counting.
- R11: A carry moves one field per clock, so a field updates one clock after the field below it wraps. A full ripple ends within six clocks of the sub-second wrap. Prescaler steps must be at least seven clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Tick pulse fed to the prescaler |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register index |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the indexed register |
| carry_irq_o | output | 1 | Carry interrupt request |

## Verification
If the sequencer is left in the wrong state, a field moves on the wrong clock. For example, seconds still read 0x59 two clocks after the sub-second wrap, or minutes change when seconds did not wrap. A register read shows this within one clock of the carry. A miscounting prescaler shows at once as a carry interrupt arriving sooner or later than PRE_DIV clocks after start. A wrong month-length or leap decision shows at the next day rollover, as a wrong day and month pair. A carry flag that fails to set or clear shows on the interrupt pin in the following clock.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEC,
        ST_MIN,
        ST_HOUR,
        ST_DAY,
        ST_MON,
        ST_YEAR
    } seq_state_t;

    localparam logic [3:0] IDX_SUB  = 4'd0;
    localparam logic [3:0] IDX_SEC  = 4'd1;
    localparam logic [3:0] IDX_MIN  = 4'd2;
    localparam logic [3:0] IDX_HOUR = 4'd3;
    localparam logic [3:0] IDX_WDAY = 4'd4;
    localparam logic [3:0] IDX_DAY  = 4'd5;
    localparam logic [3:0] IDX_MON  = 4'd6;
    localparam logic [3:0] IDX_YEAR = 4'd7;
    localparam logic [3:0] IDX_CENT = 4'd8;
    localparam logic [3:0] IDX_CTLA = 4'd14;
    localparam logic [3:0] IDX_CTLB = 4'd15;

    // next packed-BCD value, low digit rolls 9 -> 0 with a tens carry
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
        return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRE_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic run_i,
    input  logic hold_i,
    output logic step_o
);
    localparam int CW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRE_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (hold_i)           cnt_q <= '0;
        else if (run_i && tick_i)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign step_o = run_i && !hold_i && tick_i && (cnt_q == LAST);

    // R7: a held prescaler sits at zero on the next clock
    assert_hold_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (cnt_q == '0));

    generate
        if (PRE_DIV > 1) begin : g_spacing
            // R7: two steps never come on back-to-back clocks
            assert_step_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
                step_o |=> !step_o);
        end
    endgenerate

endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len (
    input  logic [7:0] mon_i,
    input  logic [7:0] year_i,
    output logic [7:0] last_day_o
);
    import rtc_pkg::*;

    logic [7:0] year_bin;
    logic       leap;

    assign year_bin = bcd_to_bin(year_i);
    assign leap     = (year_bin[1:0] == 2'b00);

    always_comb begin
        unique case (mon_i)
            8'h02:                      last_day_o = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day_o = 8'h30;
            default:                    last_day_o = 8'h31;
        endcase
    end

endmodule

// File: rtl/rtc_time_seq.sv
module rtc_time_seq #(
    parameter int SUB_W     = 6,
    parameter bit WIDE_YEAR = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             step_i,
    input  logic             wr_en_i,
    input  logic [3:0]       wr_idx_i,
    input  logic [7:0]       wr_data_i,
    output logic [SUB_W-1:0] sub_o,
    output logic [7:0]       sec_o,
    output logic [7:0]       min_o,
    output logic [7:0]       hour_o,
    output logic [7:0]       wday_o,
    output logic [7:0]       day_o,
    output logic [7:0]       mon_o,
    output logic [7:0]       year_o,
    output logic [7:0]       cent_o,
    output logic             sec_carry_o
);
    import rtc_pkg::*;

    localparam logic [SUB_W-1:0] SUB_LAST = {SUB_W{1'b1}};

    seq_state_t state_q, state_d;
    logic [SUB_W-1:0] sub_q;
    logic [7:0] sec_q, min_q, hour_q, wday_q, day_q, mon_q, year_q;
    logic [7:0] last_day;
    logic       load;

    rtc_month_len u_month_len (
        .mon_i      (mon_q),
        .year_i     (year_q),
        .last_day_o (last_day)
    );

    assign load        = wr_en_i && !run_i;
    assign sec_carry_o = run_i && (state_q == ST_IDLE) && step_i && (sub_q == SUB_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: one field per clock, stop early when a field does not wrap
    always_comb begin
        state_d = state_q;
        if (run_i) begin
            unique case (state_q)
                ST_IDLE: state_d = (step_i && sub_q == SUB_LAST) ? ST_SEC : ST_IDLE;
                ST_SEC:  state_d = (sec_q  >= 8'h59) ? ST_MIN  : ST_IDLE;
                ST_MIN:  state_d = (min_q  >= 8'h59) ? ST_HOUR : ST_IDLE;
                ST_HOUR: state_d = (hour_q >= 8'h23) ? ST_DAY  : ST_IDLE;
                ST_DAY:  state_d = (day_q  >= last_day) ? ST_MON : ST_IDLE;
                ST_MON:  state_d = (mon_q  >= 8'h12) ? ST_YEAR : ST_IDLE;
                ST_YEAR: state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // counter updates driven by the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q  <= '0;
            sec_q  <= 8'h00;
            min_q  <= 8'h00;
            hour_q <= 8'h00;
            wday_q <= 8'h00;
            day_q  <= 8'h01;
            mon_q  <= 8'h01;
            year_q <= 8'h00;
        end else if (load) begin
            case (wr_idx_i)
                IDX_SUB:  sub_q  <= wr_data_i[SUB_W-1:0];
                IDX_SEC:  sec_q  <= wr_data_i;
                IDX_MIN:  min_q  <= wr_data_i;
                IDX_HOUR: hour_q <= wr_data_i;
                IDX_WDAY: wday_q <= wr_data_i;
                IDX_DAY:  day_q  <= wr_data_i;
                IDX_MON:  mon_q  <= wr_data_i;
                IDX_YEAR: year_q <= wr_data_i;
                default:  ;
            endcase
        end else if (run_i) begin
            unique case (state_q)
                ST_IDLE: if (step_i) sub_q <= sub_q + 1'b1;
                ST_SEC:  sec_q  <= (sec_q  >= 8'h59) ? 8'h00 : bcd_inc(sec_q);
                ST_MIN:  min_q  <= (min_q  >= 8'h59) ? 8'h00 : bcd_inc(min_q);
                ST_HOUR: hour_q <= (hour_q >= 8'h23) ? 8'h00 : bcd_inc(hour_q);
                ST_DAY: begin
                    wday_q <= (wday_q >= 8'h06) ? 8'h00 : wday_q + 8'd1;
                    day_q  <= (day_q >= last_day) ? 8'h01 : bcd_inc(day_q);
                end
                ST_MON:  mon_q  <= (mon_q  >= 8'h12) ? 8'h01 : bcd_inc(mon_q);
                ST_YEAR: year_q <= (year_q >= 8'h99) ? 8'h00 : bcd_inc(year_q);
                default: ;
            endcase
        end
    end

    generate
        if (WIDE_YEAR) begin : g_century
            logic [7:0] cent_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    cent_q <= 8'h20;
                else if (load && wr_idx_i == IDX_CENT)
                    cent_q <= wr_data_i;
                else if (run_i && state_q == ST_YEAR && year_q >= 8'h99)
                    cent_q <= (cent_q >= 8'h99) ? 8'h00 : bcd_inc(cent_q);
            end
            assign cent_o = cent_q;
        end else begin : g_no_century
            assign cent_o = 8'h00;
        end
    endgenerate

    assign sub_o  = sub_q;
    assign sec_o  = sec_q;
    assign min_o  = min_q;
    assign hour_o = hour_q;
    assign wday_o = wday_q;
    assign day_o  = day_q;
    assign mon_o  = mon_q;
    assign year_o = year_q;

    // R11: steps only arrive while the sequencer is idle
    assert_step_in_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && step_i) |-> (state_q == ST_IDLE));

    // R11: the year stage always ends the ripple
    assert_ripple_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && state_q == ST_YEAR) |=> (state_q == ST_IDLE));

    // R6: stopped and not written, nothing moves
    assert_stop_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !wr_en_i) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q)
            && $stable(day_q) && $stable(mon_q) && $stable(year_q) && $stable(state_q)));

    // R2: a wrapping step clears the sub-second count and opens the ripple
    assert_sub_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_carry_o |=> (sub_q == '0 && state_q == ST_SEC));

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core #(
    parameter int PRE_DIV   = 8,
    parameter bit WIDE_YEAR = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       bus_wr_i,
    input  logic [3:0] bus_addr_i,
    input  logic [7:0] bus_wdata_i,
    output logic [7:0] bus_rdata_o,
    output logic       carry_irq_o
);
    import rtc_pkg::*;

    localparam int SUB_W = 6;

    logic start_q, prst_q, adj_q, en_q;
    logic cf_q, cie_q;
    logic step, sec_carry, cnt_wr, ctla_wr, ctlb_wr;
    logic [SUB_W-1:0] sub;
    logic [7:0] sec, min, hour, wday, day, mon, year, cent;

    assign cnt_wr  = bus_wr_i && (bus_addr_i <= IDX_CENT);
    assign ctla_wr = bus_wr_i && (bus_addr_i == IDX_CTLA);
    assign ctlb_wr = bus_wr_i && (bus_addr_i == IDX_CTLB);

    rtc_prescaler #(.PRE_DIV(PRE_DIV)) u_prescaler (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .run_i  (start_q),
        .hold_i (prst_q),
        .step_o (step)
    );

    rtc_time_seq #(.SUB_W(SUB_W), .WIDE_YEAR(WIDE_YEAR)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (start_q),
        .step_i      (step),
        .wr_en_i     (cnt_wr),
        .wr_idx_i    (bus_addr_i),
        .wr_data_i   (bus_wdata_i),
        .sub_o       (sub),
        .sec_o       (sec),
        .min_o       (min),
        .hour_o      (hour),
        .wday_o      (wday),
        .day_o       (day),
        .mon_o       (mon),
        .year_o      (year),
        .cent_o      (cent),
        .sec_carry_o (sec_carry)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            prst_q  <= 1'b0;
            adj_q   <= 1'b0;
            en_q    <= 1'b0;
            cie_q   <= 1'b0;
            cf_q    <= 1'b0;
        end else begin
            if (ctlb_wr) begin
                start_q <= bus_wdata_i[0];
                prst_q  <= bus_wdata_i[1];
                adj_q   <= bus_wdata_i[2];
                en_q    <= bus_wdata_i[3];
            end
            if (ctla_wr) cie_q <= bus_wdata_i[4];
            if (sec_carry)                        cf_q <= 1'b1;
            else if (ctla_wr && !bus_wdata_i[7])  cf_q <= 1'b0;
        end
    end

    always_comb begin
        case (bus_addr_i)
            IDX_SUB:  bus_rdata_o = 8'(sub);
            IDX_SEC:  bus_rdata_o = sec;
            IDX_MIN:  bus_rdata_o = min;
            IDX_HOUR: bus_rdata_o = hour;
            IDX_WDAY: bus_rdata_o = wday;
            IDX_DAY:  bus_rdata_o = day;
            IDX_MON:  bus_rdata_o = mon;
            IDX_YEAR: bus_rdata_o = year;
            IDX_CENT: bus_rdata_o = cent;
            IDX_CTLA: bus_rdata_o = {cf_q, 2'b00, cie_q, 4'b0000};
            IDX_CTLB: bus_rdata_o = {4'b0000, en_q, adj_q, prst_q, start_q};
            default:  bus_rdata_o = 8'h00;
        endcase
    end

    assign carry_irq_o = cf_q && cie_q;

    // R8: a seconds carry always leaves the flag set, even against a clearing write
    assert_flag_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sec_carry |=> cf_q);

    // R8: only a zero written to bit 7 can drop the flag
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cf_q && !(ctla_wr && !bus_wdata_i[7])) |=> cf_q);

    // R9: an enabled carry reaches the interrupt pin on the next clock
    assert_irq_on_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_carry && cie_q && !ctla_wr) |=> carry_irq_o);

    // R7: no step is produced while stopped
    assert_no_step_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !start_q |-> !step);

endmodule

// File: tb/bcd_rtc_core_tb.sv
module bcd_rtc_core_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PRE_DIV    = 8;
    localparam int NVEC       = 11;
    localparam logic [3:0] CTLA = 4'd14;
    localparam logic [3:0] CTLB = 4'd15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       wr = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0] r;
    int k;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bcd_rtc_core #(.PRE_DIV(PRE_DIV), .WIDE_YEAR(1'b1)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .carry_irq_o (irq)
    );

    // fields: sec, min, hour, wday, day, mon, year, century (indices 1..8)
    localparam logic [7:0] PRE_V [0:NVEC-1][0:7] = '{
        '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h24, 8'h20},
        '{8'h59, 8'h34, 8'h12, 8'h02, 8'h15, 8'h06, 8'h24, 8'h20},
        '{8'h59, 8'h59, 8'h09, 8'h03, 8'h10, 8'h07, 8'h24, 8'h20},
        '{8'h59, 8'h59, 8'h23, 8'h06, 8'h15, 8'h03, 8'h24, 8'h20},
        '{8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h23, 8'h20},
        '{8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h20},
        '{8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24, 8'h20},
        '{8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24, 8'h20},
        '{8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99, 8'h20},
        '{8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h01, 8'h25, 8'h20},
        '{8'h59, 8'h59, 8'h23, 8'h00, 8'h30, 8'h09, 8'h25, 8'h20}
    };
    localparam logic [7:0] EXP_V [0:NVEC-1][0:7] = '{
        '{8'h01, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h24, 8'h20},
        '{8'h00, 8'h35, 8'h12, 8'h02, 8'h15, 8'h06, 8'h24, 8'h20},
        '{8'h00, 8'h00, 8'h10, 8'h03, 8'h10, 8'h07, 8'h24, 8'h20},
        '{8'h00, 8'h00, 8'h00, 8'h00, 8'h16, 8'h03, 8'h24, 8'h20},
        '{8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h05, 8'h23, 8'h20},
        '{8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 8'h23, 8'h20},
        '{8'h00, 8'h00, 8'h00, 8'h04, 8'h29, 8'h02, 8'h24, 8'h20},
        '{8'h00, 8'h00, 8'h00, 8'h05, 8'h01, 8'h03, 8'h24, 8'h20},
        '{8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h00, 8'h21},
        '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h02, 8'h25, 8'h20},
        '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h10, 8'h25, 8'h20}
    };

    function automatic string field_tag(input int f);
        case (f)
            0: return "R3 seconds";
            1: return "R3 minutes";
            2: return "R3 hours";
            3: return "R4 weekday";
            4: return "R4 day";
            5: return "R5 month";
            6: return "R5 year";
            default: return "R5 century";
        endcase
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a falling edge, returns at the next falling edge
    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        bus_read(4'd0, r); chk(r, 8'h00, "R1 reset sub-second");
        bus_read(4'd1, r); chk(r, 8'h00, "R1 reset seconds");
        bus_read(4'd3, r); chk(r, 8'h00, "R1 reset hours");
        bus_read(4'd5, r); chk(r, 8'h01, "R1 reset day");
        bus_read(4'd6, r); chk(r, 8'h01, "R1 reset month");
        bus_read(4'd7, r); chk(r, 8'h00, "R1 reset year");
        bus_read(4'd8, r); chk(r, 8'h20, "R1 reset century");
        bus_read(CTLA, r); chk(r, 8'h00, "R1 reset control A");
        bus_read(CTLB, r); chk(r, 8'h00, "R1 reset control B");
        chk({7'd0, irq}, 8'h00, "R1 reset interrupt");

        // table walk: one second carry from each preload
        for (int v = 0; v < NVEC; v++) begin
            bus_write(CTLB, 8'h02);
            bus_write(4'd0, 8'h3F);
            for (int f = 0; f < 8; f++) bus_write(4'(f + 1), PRE_V[v][f]);
            bus_write(CTLA, 8'h10);
            bus_write(CTLB, 8'h09);
            k = 0;
            while (!irq && k < 40) begin
                @(negedge clk);
                k++;
            end
            chk(8'(k), 8'(PRE_DIV), "R7 clocks to first step");
            if (v > 0) begin
                bus_read(4'd1, r); chk(r, 8'h59, "R11 seconds before their stage");
                @(negedge clk);
                bus_read(4'd1, r); chk(r, 8'h00, "R11 seconds one clock later");
                repeat (4) @(negedge clk);
            end else begin
                repeat (5) @(negedge clk);
            end
            bus_write(CTLB, 8'h08);
            bus_read(4'd0, r); chk(r, 8'h00, "R2 sub-second wrapped");
            for (int f = 0; f < 8; f++) begin
                bus_read(4'(f + 1), r);
                chk(r, EXP_V[v][f], field_tag(f));
            end
        end

        // R8 / R9 flag handling
        bus_read(CTLA, r); chk(r, 8'h90, "R8 flag set after carry");
        chk({7'd0, irq}, 8'h01, "R9 interrupt with enable");
        bus_write(CTLA, 8'h90);
        bus_read(CTLA, r); chk(r, 8'h90, "R8 writing 1 keeps flag");
        bus_write(CTLA, 8'h80);
        chk({7'd0, irq}, 8'h00, "R9 interrupt masked");
        bus_read(CTLA, r); chk(r, 8'h80, "R8 flag kept while masked");
        bus_write(CTLA, 8'h00);
        bus_read(CTLA, r); chk(r, 8'h00, "R8 writing 0 clears flag");

        // R10 readback of stored bits
        bus_write(CTLB, 8'h0E);
        bus_read(CTLB, r); chk(r, 8'h0E, "R10 control B readback");

        // R7 hold and R6 ignored writes while running
        bus_write(CTLB, 8'h02);
        bus_write(4'd0, 8'h3F);
        bus_write(4'd1, 8'h12);
        bus_write(CTLB, 8'h03);
        bus_write(4'd1, 8'h45);
        repeat (40) @(negedge clk);
        bus_write(CTLB, 8'h02);
        bus_read(4'd0, r); chk(r, 8'h3F, "R7 held prescaler gives no step");
        bus_read(4'd1, r); chk(r, 8'h12, "R6 write while running ignored");
        chk({7'd0, irq}, 8'h00, "R7 no carry while held");

        // R2 counting with adjust and enable set (R10 no effect)
        bus_write(4'd0, 8'h10);
        bus_write(CTLB, 8'h0D);
        repeat (20) @(negedge clk);
        bus_write(CTLB, 8'h00);
        bus_read(4'd0, r); chk(r, 8'h12, "R2 two steps counted");
        bus_read(CTLB, r); chk(r, 8'h00, "R10 control B cleared");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule